// File: doc/BRIEF.md
# Temperature Read Sequencer with Decimal Text Output

This block controls a single-drop 1-Wire temperature sensor one level above the bit-level bus master. A pulse on `start` makes it run a fixed transaction script through the master's request/acknowledge handshake. The script is a bus reset, a skip-address command, a convert command, a conversion wait of about one second, a second bus reset, a second skip-address command, a scratchpad fetch command and two byte reads.

The two bytes read are joined into a 16-bit word, with the first byte as the low half. The word is shifted right by one, and its low eight bits become the temperature in whole degrees. That value is kept on `temp_deg`. It is split into a tens count and a units remainder by subtracting ten once per clock. The result goes out as text on a byte stream with a valid/ready handshake, for example into a UART transmitter: a four-character label that ends at a zero terminator, then two ASCII digits. `done` pulses once when the text is finished.

The conversion wait is a cycle counter whose length comes from the clock frequency and a wait time in milliseconds. Temperatures of 100 or more and below zero, and checksum checking, are outside this block.

Top module: `temp_report_seq`

## Requirements
- R1: After reset, `ow_req`, `tx_valid` and `done` are low and `temp_deg` is zero.
- R2: Each measurement issues exactly eight bus operations, in this order, on `ow_op` (0 = bus reset, 1 = write byte in `ow_wdata`, 2 = read byte): reset, write 0xCC, write 0x44, reset, write 0xCC, write 0xBE, read, read.
- R3: While `ow_req` is high and `ow_ack` is low, `ow_req`, `ow_op` and `ow_wdata` hold. In the cycle after `ow_ack` is seen with `ow_req` high, `ow_req` is low.
- R4: Between the acknowledge of the 0x44 write and the next request, at least CONV_CYCLES = (CLK_HZ/1000)*CONV_MS clock cycles pass.
- R5: The first read byte is the low half and the second is the high half. `temp_deg` becomes bits 8 down to 1 of {high, low} and holds that value until the next measurement.
- R6: The text sent is 0x57, 0x65, 0x72, 0x74 ("Wert"), then 0x30 + temp_deg/10, then 0x30 + temp_deg%10. That is six bytes in total.
- R7: While `tx_valid` is high and `tx_ready` is low, `tx_valid` stays high and `tx_data` holds.
- R8: `done` is high for exactly one cycle per measurement, in the cycle right after the last text byte is accepted.
- R9: A `start` pulse while a measurement is in progress has no effect: no extra bus operations, text bytes or `done` pulses appear.
- R10: `ow_req` and `tx_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launches one measurement when idle |
| done | output | 1 | One-cycle pulse after the last text byte |
| temp_deg | output | 8 | Last measured temperature, whole degrees |
| ow_req | output | 1 | Bus operation request to the 1-Wire master |
| ow_op | output | 2 | Operation: 0 reset, 1 write, 2 read |
| ow_wdata | output | 8 | Byte to write |
| ow_ack | input | 1 | Master finished the requested operation |
| ow_rdata | input | 8 | Byte read, valid with `ow_ack` |
| tx_data | output | 8 | Text byte |
| tx_valid | output | 1 | Text byte is valid |
| tx_ready | input | 1 | Sink accepts the text byte |

## Verification
Some properties are checked on every cycle by assertions:
- the bus request holds until acknowledged and drops right after the acknowledge;
- the text byte holds under back-pressure;
- `done` never lasts more than one cycle;
- the bus and text phases never overlap;
- a counter confirms the minimum conversion gap.

Other behaviour only the bench scenarios can show. That covers the order and values of the command script, the byte order of the reading, the shift-by-one result (including high-byte bits that must drop out), the exact label and digit text at the 0, 9, 10 and 99 boundaries, and that a `start` pulse during a running measurement is ignored.

// File: rtl/trs_pkg.sv
package trs_pkg;

  typedef enum logic [1:0] {
    K_RESET = 2'd0,
    K_WRITE = 2'd1,
    K_READ  = 2'd2,
    K_WAIT  = 2'd3
  } step_kind_e;

  typedef struct packed {
    step_kind_e  kind;
    logic [7:0]  val;
  } step_t;

  localparam int unsigned SCRIPT_LEN = 9;
  localparam int unsigned STEP_W     = $clog2(SCRIPT_LEN);
  localparam int unsigned LABEL_W    = 3;

  localparam logic [7:0] CMD_SKIP    = 8'hCC;
  localparam logic [7:0] CMD_CONVERT = 8'h44;
  localparam logic [7:0] CMD_FETCH   = 8'hBE;
  localparam logic [7:0] ASCII_ZERO  = 8'h30;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DISPATCH,
    S_OW,
    S_WAIT,
    S_CONV,
    S_EMIT
  } seq_state_e;

  typedef enum logic [1:0] {
    E_LABEL,
    E_TENS,
    E_UNITS
  } emit_phase_e;

  // Measurement script, one entry per step
  function automatic step_t script_step(input logic [STEP_W-1:0] idx);
    step_t s;
    case (idx)
      4'd0:    s = '{K_RESET, 8'h00};
      4'd1:    s = '{K_WRITE, CMD_SKIP};
      4'd2:    s = '{K_WRITE, CMD_CONVERT};
      4'd3:    s = '{K_WAIT,  8'h00};
      4'd4:    s = '{K_RESET, 8'h00};
      4'd5:    s = '{K_WRITE, CMD_SKIP};
      4'd6:    s = '{K_WRITE, CMD_FETCH};
      4'd7:    s = '{K_READ,  8'h00};
      default: s = '{K_READ,  8'h00};
    endcase
    return s;
  endfunction

  // Zero-terminated label text
  function automatic logic [7:0] label_char(input logic [LABEL_W-1:0] idx);
    logic [7:0] c;
    case (idx)
      3'd0:    c = 8'h57;
      3'd1:    c = 8'h65;
      3'd2:    c = 8'h72;
      3'd3:    c = 8'h74;
      default: c = 8'h00;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/trs_conv_timer.sv
module trs_conv_timer #(
  parameter int unsigned CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic expired
);
  localparam int unsigned CW = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = CW'(CYCLES - 1);
    else if (run && (cnt_q != '0))
      cnt_d = cnt_q - CW'(1);
  end

  assign expired = run && (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load || run)
      cnt_q <= cnt_d;
  end
endmodule

// File: rtl/trs_decimal_split.sv
module trs_decimal_split #(
  parameter int unsigned W     = 8,
  parameter int unsigned RADIX = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] value,
  output logic [W-1:0] tens,
  output logic [W-1:0] units,
  output logic         done
);
  logic [W-1:0] rem_q, rem_d;
  logic [W-1:0] cnt_q, cnt_d;
  logic         busy_q, busy_d;
  logic         done_q, done_d;

  always_comb begin
    rem_d  = rem_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    done_d = 1'b0;
    if (start) begin
      rem_d  = value;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (rem_q >= W'(RADIX)) begin
        rem_d = rem_q - W'(RADIX);
        cnt_d = cnt_q + W'(1);
      end else begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign tens  = cnt_q;
  assign units = rem_q;
  assign done  = done_q;
endmodule

// File: rtl/trs_text_emitter.sv
module trs_text_emitter
  import trs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tens,
  input  logic [7:0] units,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic       last_fire
);
  logic               active_q, active_d;
  emit_phase_e        phase_q, phase_d;
  logic [LABEL_W-1:0] idx_q, idx_d;
  logic [7:0]         ch;
  logic               at_term;
  logic               fire;

  assign ch      = label_char(idx_q);
  assign at_term = active_q && (phase_q == E_LABEL) && (ch == 8'h00);

  always_comb begin
    case (phase_q)
      E_TENS:  tx_data = ASCII_ZERO + tens;
      E_UNITS: tx_data = ASCII_ZERO + units;
      default: tx_data = ch;
    endcase
  end

  assign tx_valid  = active_q && !at_term;
  assign fire      = tx_valid && tx_ready;
  assign last_fire = fire && (phase_q == E_UNITS);

  always_comb begin
    active_d = active_q;
    phase_d  = phase_q;
    idx_d    = idx_q;
    if (start) begin
      active_d = 1'b1;
      phase_d  = E_LABEL;
      idx_d    = '0;
    end else if (at_term) begin
      phase_d = E_TENS;
    end else if (fire) begin
      case (phase_q)
        E_LABEL: idx_d    = idx_q + LABEL_W'(1);
        E_TENS:  phase_d  = E_UNITS;
        default: active_d = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      phase_q  <= E_LABEL;
      idx_q    <= '0;
    end else begin
      active_q <= active_d;
      phase_q  <= phase_d;
      idx_q    <= idx_d;
    end
  end
endmodule

// File: rtl/temp_report_seq.sv
module temp_report_seq
  import trs_pkg::*;
#(
  parameter int unsigned CLK_HZ  = 100_000_000,
  parameter int unsigned CONV_MS = 1000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       done,
  output logic [7:0] temp_deg,
  output logic       ow_req,
  output logic [1:0] ow_op,
  output logic [7:0] ow_wdata,
  input  logic       ow_ack,
  input  logic [7:0] ow_rdata,
  output logic [7:0] tx_data,
  output logic       tx_valid,
  input  logic       tx_ready
);
  localparam int unsigned CONV_CYCLES = (CLK_HZ / 1000) * CONV_MS;
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(SCRIPT_LEN - 1);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [7:0]        lo_q, lo_d;
  logic [7:0]        temp_q, temp_d;
  logic              done_q, done_d;

  step_t      cur;
  logic       ow_done;
  logic       last_step;
  logic [7:0] conv_val;
  logic       tmr_load, tmr_run, tmr_expired;
  logic       bcd_start, bcd_done;
  logic [7:0] bcd_tens, bcd_units;
  logic       emit_start, emit_last;

  assign cur       = script_step(step_q);
  assign ow_req    = (state_q == S_OW);
  assign ow_op     = cur.kind;
  assign ow_wdata  = cur.val;
  assign ow_done   = ow_req && ow_ack;
  assign last_step = (step_q == LAST_STEP);
  assign conv_val  = {ow_rdata[0], lo_q[7:1]};

  assign tmr_load   = (state_q == S_DISPATCH) && (cur.kind == K_WAIT);
  assign tmr_run    = (state_q == S_WAIT);
  assign bcd_start  = ow_done && last_step;
  assign emit_start = (state_q == S_CONV) && bcd_done;

  always_comb begin
    state_d = state_q;
    step_d  = step_q;
    lo_d    = lo_q;
    temp_d  = temp_q;
    done_d  = 1'b0;
    case (state_q)
      S_IDLE: begin
        if (start) begin
          step_d  = '0;
          state_d = S_DISPATCH;
        end
      end
      S_DISPATCH: begin
        state_d = (cur.kind == K_WAIT) ? S_WAIT : S_OW;
      end
      S_OW: begin
        if (ow_done) begin
          if (last_step) begin
            temp_d  = conv_val;
            state_d = S_CONV;
          end else begin
            if (cur.kind == K_READ)
              lo_d = ow_rdata;
            step_d  = step_q + STEP_W'(1);
            state_d = S_DISPATCH;
          end
        end
      end
      S_WAIT: begin
        if (tmr_expired) begin
          step_d  = step_q + STEP_W'(1);
          state_d = S_DISPATCH;
        end
      end
      S_CONV: begin
        if (bcd_done)
          state_d = S_EMIT;
      end
      S_EMIT: begin
        if (emit_last) begin
          done_d  = 1'b1;
          state_d = S_IDLE;
        end
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      step_q  <= '0;
      lo_q    <= '0;
      temp_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      step_q  <= step_d;
      lo_q    <= lo_d;
      temp_q  <= temp_d;
      done_q  <= done_d;
    end
  end

  assign done     = done_q;
  assign temp_deg = temp_q;

  trs_conv_timer #(.CYCLES(CONV_CYCLES)) timer_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (tmr_load),
    .run     (tmr_run),
    .expired (tmr_expired)
  );

  trs_decimal_split #(.W(8), .RADIX(10)) split_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (bcd_start),
    .value (conv_val),
    .tens  (bcd_tens),
    .units (bcd_units),
    .done  (bcd_done)
  );

  trs_text_emitter emit_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (emit_start),
    .tens      (bcd_tens),
    .units     (bcd_units),
    .tx_data   (tx_data),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .last_fire (emit_last)
  );
endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
  parameter int unsigned CONV_CYCLES = 1000
) (
  input logic       clk,
  input logic       rst_n,
  input logic       ow_req,
  input logic [1:0] ow_op,
  input logic [7:0] ow_wdata,
  input logic       ow_ack,
  input logic [7:0] tx_data,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic       done
);
  logic        armed_q;
  logic [31:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      gap_q   <= '0;
    end else if (ow_req && ow_ack && (ow_op == 2'd1) && (ow_wdata == 8'h44)) begin
      armed_q <= 1'b1;
      gap_q   <= '0;
    end else if (armed_q && ow_req) begin
      armed_q <= 1'b0;
    end else if (armed_q) begin
      gap_q <= gap_q + 32'd1;
    end
  end

  // R3
  ow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ow_req && !ow_ack) |=> (ow_req && $stable(ow_op) && $stable(ow_wdata)));

  // R3
  ow_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ow_req && ow_ack) |=> !ow_req);

  // R4
  conv_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && ow_req) |-> (gap_q >= CONV_CYCLES));

  // R7
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R8
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ow_req && tx_valid));
endmodule

bind temp_report_seq trs_checker #(.CONV_CYCLES(CONV_CYCLES)) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .ow_req   (ow_req),
  .ow_op    (ow_op),
  .ow_wdata (ow_wdata),
  .ow_ack   (ow_ack),
  .tx_data  (tx_data),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .done     (done)
);

// File: tb/temp_report_seq_tb_top.sv
`timescale 1ns/1ps
module temp_report_seq_tb_top;
  localparam int unsigned TB_CLK_HZ  = 2000;
  localparam int unsigned TB_CONV_MS = 100;
  localparam int unsigned TB_CONV    = (TB_CLK_HZ / 1000) * TB_CONV_MS;

  logic       clk;
  logic       rst_n;
  logic       start;
  logic       done;
  logic [7:0] temp_deg;
  logic       ow_req;
  logic [1:0] ow_op;
  logic [7:0] ow_wdata;
  logic       ow_ack;
  logic [7:0] ow_rdata;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready;

  int n_chk, n_bad;
  int cyc;
  bit finished;

  // logs filled by the responders
  int         n_ops, n_tx, n_done, rd_cnt;
  logic [1:0] op_log  [0:15];
  logic [7:0] dat_log [0:15];
  int         req_cyc [0:15];
  int         ack_cyc [0:15];
  logic [7:0] tx_log  [0:15];
  int         last_acc_cyc, done_cyc;
  bit         overlap;
  logic [7:0] rd_lo, rd_hi;

  temp_report_seq #(.CLK_HZ(TB_CLK_HZ), .CONV_MS(TB_CONV_MS)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .done     (done),
    .temp_deg (temp_deg),
    .ow_req   (ow_req),
    .ow_op    (ow_op),
    .ow_wdata (ow_wdata),
    .ow_ack   (ow_ack),
    .ow_rdata (ow_rdata),
    .tx_data  (tx_data),
    .tx_valid (tx_valid),
    .tx_ready (tx_ready)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_temp(input logic [7:0] hi, input logic [7:0] lo);
    logic [15:0] w;
    w = {hi, lo};
    return w[8:1];
  endfunction

  // 1-Wire master model with random latency
  task automatic ow_responder();
    bit         pend;
    int         lat;
    logic [1:0] op0;
    logic [7:0] d0;
    pend = 0;
    lat  = 0;
    forever begin
      @(negedge clk);
      if (ow_ack) begin
        ow_ack = 1'b0;
      end else if (ow_req) begin
        if (!pend) begin
          pend = 1;
          op0  = ow_op;
          d0   = ow_wdata;
          lat  = $urandom_range(0, 3);
          if (n_ops < 16) req_cyc[n_ops] = cyc;
        end
        if (lat == 0) begin
          // R3: request held stable until acknowledged
          chk((ow_op == op0) && (ow_wdata == d0), "R3 request stable",
              {ow_op, ow_wdata}, {op0, d0});
          if (n_ops < 16) begin
            op_log[n_ops]  = ow_op;
            dat_log[n_ops] = ow_wdata;
            ack_cyc[n_ops] = cyc;
          end
          n_ops++;
          if (ow_op == 2'd2) begin
            ow_rdata = (rd_cnt == 0) ? rd_lo : rd_hi;
            rd_cnt++;
          end else begin
            ow_rdata = 8'h00;
          end
          ow_ack = 1'b1;
          pend   = 0;
        end else begin
          lat--;
        end
      end
    end
  endtask

  // text sink with random back-pressure
  task automatic tx_sink();
    bit         hold;
    logic [7:0] first;
    hold = 0;
    forever begin
      @(negedge clk);
      if (ow_req && tx_valid) overlap = 1;
      if (done) begin
        n_done++;
        done_cyc = cyc;
      end
      tx_ready = ($urandom_range(0, 2) != 0);
      if (tx_valid) begin
        if (!hold) begin
          hold  = 1;
          first = tx_data;
        end
        if (tx_ready) begin
          // R7: byte unchanged while waiting for ready
          chk(tx_data == first, "R7 byte held", tx_data, first);
          if (n_tx < 16) tx_log[n_tx] = tx_data;
          n_tx++;
          last_acc_cyc = cyc;
          hold = 0;
        end
      end
    end
  endtask

  task automatic run_one(input logic [7:0] hi, input logic [7:0] lo, input bit inject);
    logic [7:0] t;
    logic [1:0] eop  [0:7];
    logic [7:0] edat [0:7];
    logic [7:0] etx  [0:5];
    t = exp_temp(hi, lo);
    eop = '{2'd0, 2'd1, 2'd1, 2'd0, 2'd1, 2'd1, 2'd2, 2'd2};
    edat = '{8'h00, 8'hCC, 8'h44, 8'h00, 8'hCC, 8'hBE, 8'h00, 8'h00};
    etx = '{8'h57, 8'h65, 8'h72, 8'h74, 8'h30 + t / 10, 8'h30 + t % 10};
    @(negedge clk);
    n_ops = 0; n_tx = 0; n_done = 0; rd_cnt = 0; overlap = 0;
    rd_lo = lo; rd_hi = hi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (inject) begin
      wait (n_ops >= 3);
      @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (n_done >= 1);
    repeat (30) @(negedge clk);
    // R2: operation script
    chk(n_ops == 8, "R2 op count", n_ops, 8);
    for (int i = 0; i < 8; i++) begin
      chk((op_log[i] == eop[i]) && ((eop[i] != 2'd1) || (dat_log[i] == edat[i])),
          "R2 op/data", {op_log[i], dat_log[i]}, {eop[i], edat[i]});
    end
    // R4: conversion wait
    chk((req_cyc[3] - ack_cyc[2]) >= TB_CONV, "R4 wait", req_cyc[3] - ack_cyc[2], TB_CONV);
    // R5: byte order and shift
    chk(temp_deg == t, "R5 temp", temp_deg, t);
    // R6: text
    chk(n_tx == 6, "R6 byte count", n_tx, 6);
    for (int i = 0; i < 6; i++)
      chk(tx_log[i] == etx[i], "R6 text byte", tx_log[i], etx[i]);
    // R8: one done pulse right after last byte
    chk(n_done == 1, "R8 done count", n_done, 1);
    chk(done_cyc == last_acc_cyc + 1, "R8 done timing", done_cyc, last_acc_cyc + 1);
    // R10: phases never overlap
    chk(!overlap, "R10 overlap", overlap, 0);
    if (inject) begin
      // R9: start while busy has no effect
      chk((n_ops == 8) && (n_tx == 6) && (n_done == 1), "R9 start ignored",
          {n_ops[7:0], n_tx[7:0], n_done[7:0]}, {8'd8, 8'd6, 8'd1});
    end
  endtask

  initial begin
    finished = 0;
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] t, lo, hi;
    void'($urandom(32'd20240611));
    n_chk = 0; n_bad = 0; cyc = 0;
    n_ops = 0; n_tx = 0; n_done = 0; rd_cnt = 0;
    rst_n = 1'b0; start = 1'b0; ow_ack = 1'b0; ow_rdata = 8'h00; tx_ready = 1'b0;
    rd_lo = 8'h00; rd_hi = 8'h00; overlap = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk(!ow_req && !tx_valid && !done && (temp_deg == 8'h00), "R1 reset state",
        {ow_req, tx_valid, done, temp_deg}, 0);
    fork
      ow_responder();
      tx_sink();
    join_none
    // directed boundary cases
    run_one(8'h00, 8'h00, 0);   // 0
    run_one(8'h00, 8'h13, 0);   // 9
    run_one(8'h00, 8'h14, 0);   // 10
    run_one(8'h00, 8'hC6, 0);   // 99
    run_one(8'hFE, 8'h32, 0);   // 25, upper high bits dropped
    run_one(8'h00, 8'h01, 0);   // 0, dropped low bit
    run_one(8'h00, 8'h54, 1);   // 42, start pulse while busy
    // constrained random temperatures 0..99
    for (int k = 0; k < 15; k++) begin
      t  = 8'($urandom_range(0, 99));
      lo = {t[6:0], 1'($urandom_range(0, 1))};
      hi = {7'($urandom_range(0, 127)), 1'b0};
      run_one(hi, lo, 0);
    end
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule